// File: doc/BRIEF.md
# Timer Tick Generator with Prescalers and Per-Channel Divider Select

This block produces the count-enable ticks for a five-channel timer. All ticks come from one base clock. Two shared prescalers first slow the base clock down. Channels 0 and 1 hang off the first prescaler, and channels 2 to 4 hang off the second. Each channel then applies its own power-of-two divider to its prescaled tick stream. A channel can instead be set to follow an external tick pin. Channels 0 and 1 use the first external pin, and channels 2 to 4 use the second.

Software configures the block through a simple write port with two word registers. The prescaler register sits at byte offset 0x0 and the selector register at byte offset 0x4. Each tick output is a single-cycle enable in the base clock domain. A timer counter downstream can use it directly as a count enable.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_n` is low, every tick output is 0. Reset clears both prescaler fields and all five selector fields to 0.
- R2: A write to offset 0x0 loads prescaler 0 from `wr_data[7:0]` and prescaler 1 from `wr_data[15:8]`. A prescaler whose field holds value p gives one prescaled tick every p+1 base clocks.
- R3: Channels 0 and 1 are driven from prescaler 0. Channels 2, 3 and 4 are driven from prescaler 1.
- R4: A write to offset 0x4 loads the selector of channel n from `wr_data[4n+3:4n]`. A selector code s from 0 to 4 gives one channel tick per 2^(s+DIV_BASE) prescaled ticks. With DIV_BASE = 0, code 0 ticks on every prescaled tick.
- R5: Selector codes 5, 6 and 7 switch the channel to an external source. Channels 0 and 1 follow `ext_tick[0]`, and channels 2 to 4 follow `ext_tick[1]`. Each pin passes through a two-flop synchroniser. Each rising edge of a pin gives exactly one tick, which appears after the second clock edge that samples the new level.
- R6: Selector codes 8 to 15 stop the channel, so its tick output stays 0.
- R7: A write to offset 0x0 restarts both prescaler counters and every channel divider counter from zero on the next clock. A write to offset 0x4 restarts only the channel divider counters.
- R8: A write to any offset other than 0x0 or 0x4 changes no configuration and restarts no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Byte offset of the write |
| wr_data | input | DATA_W (32) | Write data |
| ext_tick | input | 2 | External tick pins, one per channel group |
| tick | output | 5 | Single-cycle tick enable per channel |

## Verification
The bench aims at the points where a tick lands relative to a configuration write.

- **Restart timing (R7).** Writes arrive mid-period to each register, so the bench can catch a design whose restart lags by a cycle, or one whose selector write also resets the prescalers. Either fault shifts every later tick.
- **Group wiring (R3, R5).** The two prescalers get different values, so swapped group wiring shows up as wrong tick spacing.
- **External pins (R5).** The external pins get one-cycle and long pulses. A design without edge detection would emit a tick burst, and one with the wrong synchroniser depth would emit the tick a cycle off.
- **Decode edges (R6, R8).** Stop codes and writes to unused offsets catch decode that is too loose.

// File: rtl/timer_tick_gen_pkg.sv
package timer_tick_gen_pkg;

    localparam int NCH          = 5;
    localparam int NGRP         = 2;
    localparam int G0_CHANS     = 2;
    localparam int DIV_CODE_MAX = 4;
    localparam int EXT_CODE_LO  = 5;
    localparam int EXT_CODE_HI  = 7;

    function automatic int group_of(input int ch);
        return (ch < G0_CHANS) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         pulse
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        pulse = (st_q.cnt == limit);
        if (restart) begin
            st_d.cnt = '0;
        end else if (pulse) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ext_edge_sync.sv
module ext_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] last;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
        rise      = st_q.sync & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/chan_div_select.sv
module chan_div_select
    import timer_tick_gen_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic             ext_rise,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);

    localparam int EXP_MAX = DIV_CODE_MAX + DIV_BASE;
    localparam int CW      = (EXP_MAX > 0) ? EXP_MAX : 1;
    localparam logic [SEL_W-1:0] DIV_LAST = SEL_W'(DIV_CODE_MAX);
    localparam logic [SEL_W-1:0] EXT_LO   = SEL_W'(EXT_CODE_LO);
    localparam logic [SEL_W-1:0] EXT_HI   = SEL_W'(EXT_CODE_HI);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t        st_d, st_q;
    logic          is_div;
    logic          is_ext;
    logic [CW-1:0] wrap_at;
    int            expo;

    always_comb begin
        st_d    = st_q;
        is_div  = (code <= DIV_LAST);
        is_ext  = (code >= EXT_LO) && (code <= EXT_HI);
        expo    = int'(code) + DIV_BASE;
        wrap_at = is_div ? CW'((32'd1 << expo) - 32'd1) : '0;

        if (is_div) begin
            tick = pre_tick && (st_q.cnt == wrap_at);
        end else if (is_ext) begin
            tick = ext_rise;
        end else begin
            tick = 1'b0;
        end

        if (restart) begin
            st_d.cnt = '0;
        end else if (is_div && pre_tick) begin
            st_d.cnt = (st_q.cnt == wrap_at) ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
    import timer_tick_gen_pkg::*;
#(
    parameter int PSC_W    = 8,
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 0,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        ext_tick,
    output logic [4:0]        tick
);

    localparam logic [ADDR_W-1:0] OFS_PSC = '0;
    localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(4);
    localparam int                SEL_TOP = NCH * SEL_W;

    typedef struct packed {
        logic [NGRP-1:0][PSC_W-1:0] psc;
        logic [NCH-1:0][SEL_W-1:0]  sel;
    } cfg_t;

    cfg_t                       cfg_d, cfg_q;
    logic [NGRP-1:0][PSC_W-1:0] psc_q;
    logic [NCH-1:0][SEL_W-1:0]  sel_q;
    logic                       hit_psc;
    logic                       hit_sel;
    logic                       restart_pre;
    logic                       restart_div;
    logic [NGRP-1:0]            pre_tick;
    logic [NGRP-1:0]            ext_rise;
    logic [NCH-1:0]             raw_tick;
    logic                       unused_data;

    assign unused_data = ^wr_data[DATA_W-1:SEL_TOP];

    always_comb begin
        cfg_d       = cfg_q;
        hit_psc     = wr_en && (wr_addr == OFS_PSC);
        hit_sel     = wr_en && (wr_addr == OFS_SEL);
        restart_pre = hit_psc;
        restart_div = hit_psc || hit_sel;
        if (hit_psc) begin
            for (int g = 0; g < NGRP; g++) begin
                cfg_d.psc[g] = wr_data[g*PSC_W +: PSC_W];
            end
        end
        if (hit_sel) begin
            for (int c = 0; c < NCH; c++) begin
                cfg_d.sel[c] = wr_data[c*SEL_W +: SEL_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign psc_q = cfg_q.psc;
    assign sel_q = cfg_q.sel;

    for (genvar g = 0; g < NGRP; g++) begin : g_psc
        tick_prescaler #(.W(PSC_W)) u_psc (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart_pre),
            .limit   (psc_q[g]),
            .pulse   (pre_tick[g])
        );
    end

    ext_edge_sync #(.N(NGRP)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_tick),
        .rise  (ext_rise)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int GRP = group_of(c);
        chan_div_select #(
            .SEL_W    (SEL_W),
            .DIV_BASE (DIV_BASE)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart_div),
            .pre_tick (pre_tick[GRP]),
            .ext_rise (ext_rise[GRP]),
            .code     (sel_q[c]),
            .tick     (raw_tick[c])
        );
    end

    assign tick = raw_tick & {NCH{rst_n}};

endmodule

// File: rtl/timer_tick_gen_chk.sv
module timer_tick_gen_chk
    import timer_tick_gen_pkg::*;
#(
    parameter int PSC_W    = 8,
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 0,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [4:0]                 tick,
    input logic [NGRP-1:0][PSC_W-1:0] psc_q,
    input logic [NCH-1:0][SEL_W-1:0]  sel_q
);

    localparam logic [SEL_W-1:0] DIV_LAST = SEL_W'(DIV_CODE_MAX);
    localparam logic [SEL_W-1:0] EXT_LO   = SEL_W'(EXT_CODE_LO);
    localparam logic [SEL_W-1:0] EXT_HI   = SEL_W'(EXT_CODE_HI);

    always_comb begin
        if (!rst_n) begin
            AST_QUIET_IN_RESET: assert (tick == '0); // R1
        end
    end

    AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && wr_data[PSC_W-1:0] != '0)
        |=> !(tick[0] && sel_q[0] <= DIV_LAST)); // R7

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = group_of(c);

        AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[c] > EXT_HI) |-> !tick[c]); // R6

        AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && sel_q[c] >= EXT_LO && sel_q[c] <= EXT_HI)
            |=> !(tick[c] && sel_q[c] >= EXT_LO && sel_q[c] <= EXT_HI)); // R5

        AST_DIV_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && !wr_en && sel_q[c] <= DIV_LAST
             && ((int'(sel_q[c]) + DIV_BASE) != 0 || psc_q[GRP] != '0))
            |=> !tick[c]); // R4
    end

endmodule

bind timer_tick_gen timer_tick_gen_chk #(
    .PSC_W    (PSC_W),
    .SEL_W    (SEL_W),
    .DIV_BASE (DIV_BASE),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tick    (tick),
    .psc_q   (psc_q),
    .sel_q   (sel_q)
);

// File: tb/timer_tick_gen_bench.sv
`timescale 1ns/1ps
module timer_tick_gen_bench;

    localparam int DIV_BASE = 0;
    localparam int MAX_CYC  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ext_tick = '0;
    logic [4:0]  tick;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int m_pc[2];
    int m_mp[2];
    int m_dc[5];
    int m_ms[5];
    bit m_s1[2];
    bit m_s2[2];
    bit m_s3[2];

    always #2.5 clk = ~clk;

    timer_tick_gen #(.DIV_BASE(DIV_BASE)) u_timer_tick_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    function automatic int grp(input int c);
        return (c < 2) ? 0 : 1;
    endfunction

    function automatic bit exp_tick(input int c);
        int g;
        bit pre;
        if (!rst_n) return 1'b0;
        g   = grp(c);
        pre = (m_pc[g] == m_mp[g]);
        if (m_ms[c] <= 4) return pre && (m_dc[c] == ((1 << (m_ms[c] + DIV_BASE)) - 1));
        if (m_ms[c] <= 7) return m_s2[g] && !m_s3[g];
        return 1'b0;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit pre[2];
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                m_pc[g] = 0; m_mp[g] = 0; m_s1[g] = 0; m_s2[g] = 0; m_s3[g] = 0;
            end
            for (int c = 0; c < 5; c++) begin
                m_dc[c] = 0; m_ms[c] = 0;
            end
        end else begin
            for (int g = 0; g < 2; g++) pre[g] = (m_pc[g] == m_mp[g]);
            if (wr_en && wr_addr == 4'h0) begin
                m_mp[0] = int'(wr_data[7:0]);
                m_mp[1] = int'(wr_data[15:8]);
                for (int g = 0; g < 2; g++) m_pc[g] = 0;
                for (int c = 0; c < 5; c++) m_dc[c] = 0;
            end else begin
                for (int g = 0; g < 2; g++) m_pc[g] = pre[g] ? 0 : m_pc[g] + 1;
                if (wr_en && wr_addr == 4'h4) begin
                    for (int c = 0; c < 5; c++) begin
                        m_ms[c] = int'(wr_data[c*4 +: 4]);
                        m_dc[c] = 0;
                    end
                end else begin
                    for (int c = 0; c < 5; c++) begin
                        if (m_ms[c] <= 4 && pre[grp(c)])
                            m_dc[c] = (m_dc[c] + 1) % (1 << (m_ms[c] + DIV_BASE));
                    end
                end
            end
            for (int g = 0; g < 2; g++) begin
                m_s3[g] = m_s2[g];
                m_s2[g] = m_s1[g];
                m_s1[g] = ext_tick[g];
            end
        end
    end

    task automatic compare();
        for (int c = 0; c < 5; c++) begin
            bit e;
            e = exp_tick(c);
            total++;
            if (tick[c] !== e) begin
                bad++;
                $display("FAIL %s ch%0d cycle %0d: tick actual=%0b expected=%0b",
                         cur_req, c, cyc, tick[c], e);
            end
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            compare();
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step(1);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] sel_word(input int a, input int b, input int c,
                                             input int d, input int e);
        return {12'h0, 4'(e), 4'(d), 4'(c), 4'(b), 4'(a)};
    endfunction

    initial begin
        #(MAX_CYC * 5.0);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset
        cur_req = "R1";
        @(negedge clk);
        compare();
        step(3);
        rst_n = 1'b1;
        // R4: defaults give code 0 and prescale 0, so a tick on every clock
        cur_req = "R4";
        step(20);

        // R2: both prescalers at 3
        cur_req = "R2";
        write_reg(4'h0, 32'h0000_0303);
        step(40);

        // R3: distinct prescale values per group
        cur_req = "R3";
        write_reg(4'h0, 32'h0000_0502);
        step(60);

        // R4: each divide code on some channel
        cur_req = "R4";
        write_reg(4'h0, 32'h0000_0001);
        write_reg(4'h4, sel_word(1, 2, 3, 4, 0));
        step(200);

        // R5: external sources with short and long pulses
        cur_req = "R5";
        write_reg(4'h4, sel_word(5, 6, 7, 5, 1));
        for (int k = 0; k < 8; k++) begin
            ext_tick = 2'b01;
            step(1);
            ext_tick = 2'b10;
            step(1 + k);
            ext_tick = 2'b11;
            step(4);
            ext_tick = 2'b00;
            step(3 + (k % 3));
        end

        // R6: stop codes while pins toggle
        cur_req = "R6";
        write_reg(4'h4, sel_word(8, 9, 15, 12, 4));
        for (int k = 0; k < 10; k++) begin
            ext_tick = ~ext_tick;
            step(6);
        end
        ext_tick = 2'b00;

        // R7: restarts written mid-period
        cur_req = "R7";
        write_reg(4'h0, 32'h0000_0201);
        write_reg(4'h4, sel_word(4, 3, 2, 1, 0));
        step(37);
        write_reg(4'h4, sel_word(2, 4, 1, 3, 2));
        step(23);
        write_reg(4'h0, 32'h0000_0103);
        step(50);
        write_reg(4'h0, 32'h0000_0000);
        step(9);

        // R8: writes to unused offsets
        cur_req = "R8";
        write_reg(4'h8, 32'hFFFF_FFFF);
        step(11);
        write_reg(4'hC, 32'h0007_7777);
        step(13);
        write_reg(4'h2, 32'h1234_5678);
        step(20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule